// File: doc/BRIEF.md
# Ring-Oscillator Entropy Sampler

This block turns a bank of free-running ring-oscillator outputs into raw random words in the system clock domain. The oscillator array supplies 32 asynchronous bits as 16 pairs, each pair made of a "p" bit and an "n" bit. A divider counts system clocks and, each time it wraps, captures all 32 bits straight into flip-flops. There is no synchroniser on this path, because metastability at capture is itself a source of entropy. The captured word is published either raw, or XOR-folded pair by pair into 16 debiased bits.

The sampling interval is long in normal operation (5,000,000 clocks by default, about 0.1 s at 50 MHz) so that jitter builds up between samples. A characterisation mode samples every 16 clocks instead, so that the folded-down oscillator frequency and its jitter can be measured. Each input has a stuck-at monitor that raises a per-bit alarm after a programmable number of consecutive identical samples. The first few samples after reset are discarded as warm-up, because the oscillators keep running through reset and their first captures say little.

Top module: `entropySampler`

## Requirements
- R1: While `rstN` is low, `dataOut`, `dataValid` and `stuckAlarm` are all zero, whatever the oscillator inputs do.
- R2: In normal mode (`charMode` latched as 0), a capture happens once every `SLOW_DIV` clocks, so successive `dataValid` pulses are `SLOW_DIV` clocks apart.
- R3: In characterisation mode (`charMode` latched as 1), a capture happens once every `FAST_DIV` clocks.
- R4: In raw format, `dataOut[i]` = `oscP[i]` and `dataOut[16+i]` = `oscN[i]`, as sampled at the clock edge that ends the interval. They appear with `dataValid` one clock later.
- R5: In debiased format, `dataOut[i]` = `oscP[i]` XOR `oscN[i]` for i = 0..15, and `dataOut[31:16]` = 0.
- R6: `charMode` and `debiasEn` are taken only at the edge where the divider wraps. The value taken there picks the format of the sample captured at that edge and the length of the interval that follows. A change in the middle of an interval does not alter that interval's length.
- R7: After reset the first `WARMUP` (4) samples raise no `dataValid` and leave `dataOut` at zero. The fifth sample is the first one published.
- R8: `dataValid` is a one-clock pulse, and `dataOut` changes only in a clock where `dataValid` is high.
- R9: Each of the 32 inputs has a run counter of consecutive captures equal to the previous capture. The first capture after reset is compared with 0. `stuckAlarm[k]` (k = i for `oscP[i]`, k = 16+i for `oscN[i]`) is 1 while that count has reached `STUCK_LIMIT`. The alarm updates in the same clock as the publish stage.
- R10: A capture in which input k differs from the previous capture clears its counter, and `stuckAlarm[k]` drops in that same update clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscP | input | NUM_PAIRS | "p" oscillator of each pair, asynchronous |
| oscN | input | NUM_PAIRS | "n" oscillator of each pair, asynchronous |
| charMode | input | 1 | 1 selects the fast characterisation interval, latched at wrap |
| debiasEn | input | 1 | 1 selects XOR pair folding, latched at wrap |
| dataOut | output | 2*NUM_PAIRS | Last published sample |
| dataValid | output | 1 | One-clock strobe marking a new sample |
| stuckAlarm | output | 2*NUM_PAIRS | Per-input stuck-at alarm |

## Verification
A wrong divider count or a wrong mode latch shows up as a `dataValid` pulse one clock early or late. It is visible at the very first wrap after the fault, so within one interval. A swapped pair, a bad fold or a misplaced capture register corrupts `dataOut` on the next published sample. A run counter that clears or saturates wrongly shows as `stuckAlarm` rising one sample too soon or too late, or failing to drop on the update clock after a toggle. The reference model compares all three outputs on every clock, so every such fault is caught within one sample interval of it first taking effect.

// File: rtl/entropy_pkg.sv
package entropy_pkg;
  // Strobes issued by the control path to the datapath
  typedef struct packed {
    logic capture;  // register raw oscillator bits this edge
    logic update;   // compare/run-count stage, one cycle after capture
    logic publish;  // update stage that also drives the output
    logic debias;   // format latched at the last wrap
  } sampStrobe_t;
endpackage

// File: rtl/entropyCtrl.sv
module entropyCtrl
  import entropy_pkg::*;
#(
  parameter int SLOW_DIV = 5000000,
  parameter int FAST_DIV = 16,
  parameter int WARMUP   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        charMode,
  input  logic        debiasEn,
  output sampStrobe_t strb
);
  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int CNT_W   = $clog2(MAX_DIV + 1);
  localparam int WARM_W  = $clog2(WARMUP + 2);

  logic [CNT_W-1:0]  divCnt;
  logic [CNT_W-1:0]  divLast;
  logic              fastMode;
  logic              debLatch;
  logic              capDone;
  logic [WARM_W-1:0] warmCnt;
  logic              wrap;
  logic              warmDone;

  assign divLast  = fastMode ? CNT_W'(FAST_DIV - 1) : CNT_W'(SLOW_DIV - 1);
  assign wrap     = (divCnt == divLast);
  assign warmDone = (warmCnt == WARM_W'(WARMUP));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      fastMode <= 1'b0;
      debLatch <= 1'b0;
      capDone  <= 1'b0;
    end else begin
      capDone <= wrap;
      if (wrap) begin
        divCnt   <= '0;
        fastMode <= charMode;
        debLatch <= debiasEn;
      end else begin
        divCnt <= divCnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt <= '0;
    end else if (capDone && !warmDone) begin
      warmCnt <= warmCnt + WARM_W'(1);
    end
  end

  always_comb begin
    strb.capture = wrap;
    strb.update  = capDone;
    strb.publish = capDone && warmDone;
    strb.debias  = debLatch;
  end
endmodule

// File: rtl/entropyPath.sv
module entropyPath
  import entropy_pkg::*;
#(
  parameter int NUM_PAIRS   = 16,
  parameter int STUCK_LIMIT = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  sampStrobe_t            strb,
  input  logic [NUM_PAIRS-1:0]   oscP,
  input  logic [NUM_PAIRS-1:0]   oscN,
  output logic [2*NUM_PAIRS-1:0] dataOut,
  output logic                   dataValid,
  output logic [2*NUM_PAIRS-1:0] stuckAlarm
);
  localparam int BITS  = 2 * NUM_PAIRS;
  localparam int RUN_W = $clog2(STUCK_LIMIT + 1);

  logic [BITS-1:0] capReg;
  logic [BITS-1:0] prevReg;
  logic [BITS-1:0] folded;

  // Direct capture: metastability here is wanted as extra entropy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capReg <= '0;
    end else if (strb.capture) begin
      capReg <= {oscN, oscP};
    end
  end

  assign folded = {{NUM_PAIRS{1'b0}}, capReg[NUM_PAIRS-1:0] ^ capReg[BITS-1:NUM_PAIRS]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevReg   <= '0;
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= strb.publish;
      if (strb.update) prevReg <= capReg;
      if (strb.publish) dataOut <= strb.debias ? folded : capReg;
    end
  end

  for (genvar k = 0; k < BITS; k++) begin : g_stuck
    logic [RUN_W-1:0] runCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runCnt <= '0;
      end else if (strb.update) begin
        if (capReg[k] != prevReg[k]) runCnt <= '0;
        else if (runCnt != RUN_W'(STUCK_LIMIT)) runCnt <= runCnt + RUN_W'(1);
      end
    end
    assign stuckAlarm[k] = (runCnt == RUN_W'(STUCK_LIMIT));
  end
endmodule

// File: rtl/entropySampler.sv
module entropySampler
  import entropy_pkg::*;
#(
  parameter int NUM_PAIRS   = 16,
  parameter int SLOW_DIV    = 5000000,
  parameter int FAST_DIV    = 16,
  parameter int WARMUP      = 4,
  parameter int STUCK_LIMIT = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_PAIRS-1:0]   oscP,
  input  logic [NUM_PAIRS-1:0]   oscN,
  input  logic                   charMode,
  input  logic                   debiasEn,
  output logic [2*NUM_PAIRS-1:0] dataOut,
  output logic                   dataValid,
  output logic [2*NUM_PAIRS-1:0] stuckAlarm
);
  sampStrobe_t strb;

  entropyCtrl #(
    .SLOW_DIV(SLOW_DIV),
    .FAST_DIV(FAST_DIV),
    .WARMUP  (WARMUP)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .charMode(charMode),
    .debiasEn(debiasEn),
    .strb    (strb)
  );

  entropyPath #(
    .NUM_PAIRS  (NUM_PAIRS),
    .STUCK_LIMIT(STUCK_LIMIT)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .oscP      (oscP),
    .oscN      (oscN),
    .dataOut   (dataOut),
    .dataValid (dataValid),
    .stuckAlarm(stuckAlarm)
  );
endmodule

// File: rtl/entropySamplerChk.sv
module entropySamplerChk
  import entropy_pkg::*;
#(
  parameter int NUM_PAIRS = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input sampStrobe_t            strb,
  input logic [2*NUM_PAIRS-1:0] dataOut,
  input logic                   dataValid,
  input logic [2*NUM_PAIRS-1:0] stuckAlarm
);
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> $stable(dataOut));

  // R5
  fold_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && strb.debias) |-> (dataOut[2*NUM_PAIRS-1:NUM_PAIRS] == '0));

  // R7
  publish_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> $past(strb.update));

  // R9
  alarm_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.update) |-> $stable(stuckAlarm));

  // R2
  stage_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.capture, strb.update}));
endmodule

bind entropySampler entropySamplerChk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .strb      (strb),
  .dataOut   (dataOut),
  .dataValid (dataValid),
  .stuckAlarm(stuckAlarm)
);

// File: tb/tb_entropySampler.sv
module tb_entropySampler;
  localparam int P = 16, B = 32, SLOW = 40, FAST = 16, WARM = 4, LIM = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [P-1:0] oscP, oscN;
  logic charMode = 1'b0, debiasEn = 1'b0;
  logic [B-1:0] dataOut, stuckAlarm;
  logic dataValid;

  always #2 clk = ~clk;

  entropySampler #(.NUM_PAIRS(P), .SLOW_DIV(SLOW), .FAST_DIV(FAST),
                   .WARMUP(WARM), .STUCK_LIMIT(LIM)) dut (
    .clk(clk), .rstN(rstN), .oscP(oscP), .oscN(oscN), .charMode(charMode),
    .debiasEn(debiasEn), .dataOut(dataOut), .dataValid(dataValid),
    .stuckAlarm(stuckAlarm));

  int tests = 0, fails = 0;

  // noisy oscillator stand-in, toggling even during reset
  logic [31:0] rnd = 32'h1234_5679;
  logic [31:0] forceMask = '0, forceVal = '0;
  logic [31:0] oscBus;
  always @(negedge clk) begin
    logic [31:0] r;
    r = rnd;
    r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
    rnd <= r;
    oscBus <= (r & ~forceMask) | (forceVal & forceMask);
  end
  assign oscP = oscBus[P-1:0];
  assign oscN = oscBus[B-1:P];

  // behavioural reference model
  int mCnt, mSamples;
  bit mFast, mDeb, mPend, mValid;
  logic [B-1:0] mCap, mPrev, mData;
  int mRun[B];
  always @(posedge clk) begin
    int per;
    if (!rstN) begin
      mCnt = 0; mSamples = 0; mFast = 0; mDeb = 0; mPend = 0; mValid = 0;
      mCap = '0; mPrev = '0; mData = '0;
      for (int i = 0; i < B; i++) mRun[i] = 0;
    end else begin
      mValid = 0;
      if (mPend) begin
        mSamples++;
        for (int i = 0; i < B; i++) begin
          if (mCap[i] != mPrev[i]) mRun[i] = 0;
          else if (mRun[i] < LIM) mRun[i]++;
        end
        mPrev = mCap;
        if (mSamples > WARM) begin
          mValid = 1;
          mData = mDeb ? {16'h0, mCap[15:0] ^ mCap[31:16]} : mCap;
        end
      end
      per = mFast ? FAST : SLOW;
      if (mCnt == per - 1) begin
        mCap = {oscN, oscP}; mPend = 1; mCnt = 0;
        mFast = charMode; mDeb = debiasEn;
      end else begin
        mCnt++; mPend = 0;
      end
    end
  end

  function automatic logic [B-1:0] expAlarm();
    logic [B-1:0] a;
    for (int i = 0; i < B; i++) a[i] = (mRun[i] >= LIM);
    return a;
  endfunction

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      tests++;
      if (dataValid !== mValid || dataOut !== mData || stuckAlarm !== expAlarm()) begin
        fails++;
        if (dataValid !== mValid)
          $display("FAIL R8 dataValid act=%0b exp=%0b t=%0t", dataValid, mValid, $time);
        if (dataOut !== mData)
          $display("FAIL %s dataOut act=%h exp=%h t=%0t", mDeb ? "R5" : "R4", dataOut, mData, $time);
        if (stuckAlarm !== expAlarm())
          $display("FAIL R9 stuckAlarm act=%h exp=%h t=%0t", stuckAlarm, expAlarm(), $time);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitValid(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!dataValid && g < 100000);
  endtask

  int g, g2, early;

  initial begin
    #(150000 * 4);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(10);
    // R1: reset state with inputs toggling
    check(dataOut == 0 && !dataValid && stuckAlarm == 0, "R1 reset", dataOut, 0);
    rstN = 1'b1;
    // R7: no publish during warm-up
    early = 0;
    for (int n = 0; n < 5 * SLOW - 2; n++) begin
      cyc(1);
      if (dataValid || dataOut != 0) early++;
    end
    check(early == 0, "R7 warm-up", early, 0);
    waitValid(g);
    check(g <= 4, "R7 first publish", g, 2);
    // R2: normal interval
    waitValid(g); check(g == SLOW, "R2 slow gap", g, SLOW);
    waitValid(g); check(g == SLOW, "R2 slow gap", g, SLOW);
    // R4: raw format with a known pattern
    forceMask = '1; forceVal = 32'hA5C3_0F96;
    waitValid(g); waitValid(g);
    check(dataOut == 32'hA5C3_0F96, "R4 raw", dataOut, 32'hA5C3_0F96);
    // R5: debiased fold
    debiasEn = 1'b1;
    waitValid(g); waitValid(g);
    check(dataOut == 32'h0000_AA55, "R5 fold", dataOut, 32'h0000_AA55);
    forceMask = '0;
    cyc(SLOW * 4);
    // R6: mode taken only at wrap
    waitValid(g);
    charMode = 1'b1;
    waitValid(g); check(g == SLOW, "R6 current interval kept", g, SLOW);
    waitValid(g2); check(g2 == FAST, "R6 new interval", g2, FAST);
    // R3: characterisation interval
    waitValid(g); check(g == FAST, "R3 fast gap", g, FAST);
    debiasEn = 1'b0;
    cyc(FAST * 20);
    debiasEn = 1'b1;
    cyc(FAST * 20);
    charMode = 1'b0; debiasEn = 1'b0;
    cyc(SLOW * 3);
    // R9: stuck bits raise alarm
    waitValid(g);
    forceMask = 32'h0010_0008; forceVal = 32'h0010_0000;
    for (int k = 0; k < LIM + 2; k++) waitValid(g);
    check(stuckAlarm[3] && stuckAlarm[20], "R9 alarm set", stuckAlarm, 32'h0010_0008);
    // R10: a change clears the alarm on the next update
    forceVal = 32'h0000_0008;
    waitValid(g);
    check(!stuckAlarm[3] && !stuckAlarm[20], "R10 alarm clear", stuckAlarm, 0);
    forceMask = '0;
    cyc(SLOW * 3 + 7);
    // R1: reset mid-interval, then run warm-up again
    rstN = 1'b0;
    cyc(3);
    check(dataOut == 0 && !dataValid && stuckAlarm == 0, "R1 reset mid-run", dataOut, 0);
    rstN = 1'b1;
    early = 0;
    for (int n = 0; n < 5 * SLOW - 2; n++) begin
      cyc(1);
      if (dataValid) early++;
    end
    check(early == 0, "R7 warm-up after reset", early, 0);
    cyc(SLOW * 4);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule